// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block executes one string instruction at a time (copy, fill or compare) against a simple synchronous memory port. The caller provides the operation, the element size, a repeat code, the direction, an optional replacement for the source segment, and the values of the segment, index, count and accumulator registers. A one-cycle `start` pulse begins the work. The sequencer then walks the elements. Each element is formed from a segment shifted left by four bits plus a 16-bit offset. After each element the index registers move by the element size, and the counter counts down when a repeat code is active.

Repeated compares have two forms. The equal-repeat form stops after an element whose values differ. The unequal-repeat form stops after an element whose values match. Copies and fills ignore the zero flag and run until the counter is exhausted. When the sequencer finishes, it holds the final index and count values on its outputs and raises `done` for one cycle. For compares it also holds the subtraction flags of the last element.

Top module: `strseq_top`

## Requirements
- R1: A physical address is the segment value times 16 plus the offset, taken modulo 2^20.
- R2: Reads of the source use the `dsSeg` segment, or `overrideSeg` when `useOverride` is 1. Accesses to the destination always use `esSeg` with the destination index.
- R3: An element is 1 byte when `wordMode`=0 and 2 bytes when it is 1. After each element the stepped index registers go up by the element size when `dirDown`=0 and down when it is 1. All index values wrap modulo 65536.
- R4: `opKind`=0 (copy) reads the element at the source and writes it to the destination. It then steps both indices. Memory is little-endian: a word at byte address a keeps its low byte at a.
- R5: `opKind`=1 (fill) writes the low byte of `axIn` (byte mode) or all of `axIn` (word mode) to the destination. It steps only the destination index and makes no read request.
- R6: `opKind`=2 (compare) reads the source and then the destination. It computes source minus destination at the element width and sets the zero flag, the carry flag (borrow), the sign flag (top bit) and the overflow flag as for a subtraction. `flagPulse` is high for exactly one cycle per compared element. Both indices step.
- R7: `repMode`=0 processes exactly one element and leaves the count unchanged. `repMode`=1 or 2 repeats while the count is nonzero and decrements the count by one after each element.
- R8: With compare, `repMode`=1 stops after an element that leaves the zero flag clear, and `repMode`=2 stops after an element that leaves it set. Copy and fill ignore the zero flag.
- R9: A repeated operation that starts with a count of zero processes no element and makes no memory request. The count stays 0 and both indices keep their loaded values.
- R10: `done` is a single-cycle pulse after the last element. `busy` is high from the cycle after `start` up to and including the `done` cycle.
- R11: Read data returns one cycle after the read request. Memory requests occur only while `busy` is high. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| opKind | input | 2 | 0 copy, 1 fill, 2 compare |
| wordMode | input | 1 | 1 selects 2-byte elements |
| repMode | input | 2 | 0 once, 1 repeat while equal, 2 repeat while unequal |
| dirDown | input | 1 | 1 steps indices downward |
| useOverride | input | 1 | Use overrideSeg for the source |
| overrideSeg | input | 16 | Replacement source segment |
| dsSeg | input | 16 | Default source segment |
| esSeg | input | 16 | Destination segment |
| siIn | input | 16 | Initial source index |
| diIn | input | 16 | Initial destination index |
| cxIn | input | 16 | Initial count |
| axIn | input | 16 | Fill value |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 write, 0 read |
| memWord | output | 1 | Access is 2 bytes |
| memAddr | output | 20 | Byte address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid one cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| siOut | output | 16 | Current source index |
| diOut | output | 16 | Current destination index |
| cxOut | output | 16 | Current count |
| flagPulse | output | 1 | Compare flags just updated |
| zeroFlag | output | 1 | Difference was zero |
| carryFlag | output | 1 | Subtraction borrowed |
| signFlag | output | 1 | Top bit of difference |
| overflowFlag | output | 1 | Signed overflow of subtraction |

## Verification
The bench uses the default parameters: 16-bit registers and a 4-bit segment shift, which gives a 20-bit address. This lets it reach the corner cases at the edges of those widths. A segment of 0xFFFF with a small offset wraps to a low physical address. A destination index of 0xFFFF wraps to zero on an upward step, and a source index wraps below zero on a downward word copy. Both compare exits are exercised with a stop in mid-string, and signed overflow and borrow are checked at the 16-bit width.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

  typedef enum logic [1:0] {
    OP_COPY    = 2'd0,
    OP_FILL    = 2'd1,
    OP_COMPARE = 2'd2
  } strOp_e;

  typedef enum logic [1:0] {
    REP_ONCE     = 2'd0,
    REP_WHILE_EQ = 2'd1,
    REP_WHILE_NE = 2'd2
  } strRep_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;     // capture operands from the ports
    logic rdSrc;    // read request at source address
    logic rdDst;    // read request at destination address
    logic wrDst;    // write request at destination address
    logic useAcc;   // write data comes from accumulator
    logic capSrc;   // latch returning read data
    logic cmp;      // evaluate subtraction flags
    logic stepSi;   // move source index
    logic stepDi;   // move destination index
    logic decCx;    // count down
  } dpCtrl_t;

endpackage

// File: rtl/strseq_addr.sv
module strseq_addr #(
  parameter int REG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = REG_W + SEG_SHIFT
) (
  input  logic [REG_W-1:0]  seg,
  input  logic [REG_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);

  generate
    if (SEG_SHIFT == 0) begin : g_flat
      assign phys = seg + off;
    end else begin : g_shifted
      logic [ADDR_W-1:0] segBase;
      logic [ADDR_W-1:0] offExt;
      assign segBase = {seg, {SEG_SHIFT{1'b0}}};
      assign offExt  = {{SEG_SHIFT{1'b0}}, off};
      assign phys    = segBase + offExt;
    end
  endgenerate

endmodule

// File: rtl/strseq_ctrl.sv
module strseq_ctrl
  import strseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opKind,
  input  logic [1:0] repMode,
  input  logic       cxZero,
  input  logic       cxOne,
  input  logic       zeroFlag,
  output dpCtrl_t    ctrl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RD_SRC, S_RD_DST, S_CAP, S_WR_DST, S_CMP, S_STEP, S_FIN
  } state_e;

  state_e  state, nextState;
  strOp_e  opReg;
  strRep_e repReg;

  logic repeating, isCmp, isFill, zfExit;

  assign repeating = (repReg == REP_WHILE_EQ) || (repReg == REP_WHILE_NE);
  assign isCmp     = (opReg == OP_COMPARE);
  assign isFill    = (opReg == OP_FILL);
  assign zfExit    = isCmp && (((repReg == REP_WHILE_EQ) && !zeroFlag) ||
                               ((repReg == REP_WHILE_NE) && zeroFlag));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_COPY;
      repReg <= REP_ONCE;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        opReg  <= strOp_e'(opKind);
        repReg <= strRep_e'(repMode);
      end
    end
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          nextState = S_CHECK;
        end
      end
      S_CHECK: begin
        if (repeating && cxZero) nextState = S_FIN;
        else if (isFill)         nextState = S_WR_DST;
        else                     nextState = S_RD_SRC;
      end
      S_RD_SRC: begin
        ctrl.rdSrc = 1'b1;
        nextState  = isCmp ? S_RD_DST : S_CAP;
      end
      S_CAP: begin
        ctrl.capSrc = 1'b1;
        nextState   = S_WR_DST;
      end
      S_RD_DST: begin
        ctrl.capSrc = 1'b1;
        ctrl.rdDst  = 1'b1;
        nextState   = S_CMP;
      end
      S_WR_DST: begin
        ctrl.wrDst  = 1'b1;
        ctrl.useAcc = isFill;
        nextState   = S_STEP;
      end
      S_CMP: begin
        ctrl.cmp  = 1'b1;
        nextState = S_STEP;
      end
      S_STEP: begin
        ctrl.stepDi = 1'b1;
        ctrl.stepSi = !isFill;
        ctrl.decCx  = repeating;
        if (!repeating || cxOne || zfExit) nextState = S_FIN;
        else                               nextState = S_CHECK;
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

endmodule

// File: rtl/strseq_dp.sv
module strseq_dp
  import strseq_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = REG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              wordMode,
  input  logic              dirDown,
  input  logic              useOverride,
  input  logic [REG_W-1:0]  overrideSeg,
  input  logic [REG_W-1:0]  dsSeg,
  input  logic [REG_W-1:0]  esSeg,
  input  logic [REG_W-1:0]  siIn,
  input  logic [REG_W-1:0]  diIn,
  input  logic [REG_W-1:0]  cxIn,
  input  logic [REG_W-1:0]  axIn,
  input  logic [REG_W-1:0]  memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [REG_W-1:0]  memWdata,
  output logic [REG_W-1:0]  siOut,
  output logic [REG_W-1:0]  diOut,
  output logic [REG_W-1:0]  cxOut,
  output logic              cxZero,
  output logic              cxOne,
  output logic              flagPulse,
  output logic              zeroFlag,
  output logic              carryFlag,
  output logic              signFlag,
  output logic              overflowFlag
);

  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = REG_W / BYTE_W;

  logic [REG_W-1:0] srcSegR, dstSegR, siR, diR, cxR, axR, holdR;
  logic             wordR, dirR;
  logic             zfR, cfR, sfR, ofR, pulseR;

  logic [REG_W-1:0]  stepAmt, nextSi, nextDi;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  assign stepAmt = wordR ? REG_W'(WORD_BYTES) : REG_W'(1);
  assign nextSi  = dirR ? (siR - stepAmt) : (siR + stepAmt);
  assign nextDi  = dirR ? (diR - stepAmt) : (diR + stepAmt);

  strseq_addr #(.REG_W(REG_W), .SEG_SHIFT(SEG_SHIFT)) u_srcAddr (
    .seg(srcSegR), .off(siR), .phys(srcAddr)
  );
  strseq_addr #(.REG_W(REG_W), .SEG_SHIFT(SEG_SHIFT)) u_dstAddr (
    .seg(dstSegR), .off(diR), .phys(dstAddr)
  );

  // Subtraction at both widths; the element size picks one
  logic [BYTE_W:0] diffB;
  logic [REG_W:0]  diffW;
  logic            zfNext, cfNext, sfNext, ofNext;

  assign diffB = {1'b0, holdR[BYTE_W-1:0]} - {1'b0, memRdata[BYTE_W-1:0]};
  assign diffW = {1'b0, holdR} - {1'b0, memRdata};

  always_comb begin
    if (wordR) begin
      zfNext = (diffW[REG_W-1:0] == '0);
      cfNext = diffW[REG_W];
      sfNext = diffW[REG_W-1];
      ofNext = (holdR[REG_W-1] ^ memRdata[REG_W-1]) & (holdR[REG_W-1] ^ diffW[REG_W-1]);
    end else begin
      zfNext = (diffB[BYTE_W-1:0] == '0);
      cfNext = diffB[BYTE_W];
      sfNext = diffB[BYTE_W-1];
      ofNext = (holdR[BYTE_W-1] ^ memRdata[BYTE_W-1]) & (holdR[BYTE_W-1] ^ diffB[BYTE_W-1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSegR <= '0;
      dstSegR <= '0;
      siR     <= '0;
      diR     <= '0;
      cxR     <= '0;
      axR     <= '0;
      holdR   <= '0;
      wordR   <= 1'b0;
      dirR    <= 1'b0;
      zfR     <= 1'b0;
      cfR     <= 1'b0;
      sfR     <= 1'b0;
      ofR     <= 1'b0;
      pulseR  <= 1'b0;
    end else begin
      pulseR <= ctrl.cmp;
      if (ctrl.load) begin
        srcSegR <= useOverride ? overrideSeg : dsSeg;
        dstSegR <= esSeg;
        siR     <= siIn;
        diR     <= diIn;
        cxR     <= cxIn;
        axR     <= axIn;
        wordR   <= wordMode;
        dirR    <= dirDown;
      end
      if (ctrl.capSrc) holdR <= memRdata;
      if (ctrl.cmp) begin
        zfR <= zfNext;
        cfR <= cfNext;
        sfR <= sfNext;
        ofR <= ofNext;
      end
      if (ctrl.stepSi) siR <= nextSi;
      if (ctrl.stepDi) diR <= nextDi;
      if (ctrl.decCx)  cxR <= cxR - REG_W'(1);
    end
  end

  assign memReq   = ctrl.rdSrc | ctrl.rdDst | ctrl.wrDst;
  assign memWe    = ctrl.wrDst;
  assign memWord  = wordR;
  assign memAddr  = (ctrl.rdDst | ctrl.wrDst) ? dstAddr : srcAddr;
  assign memWdata = ctrl.useAcc ? axR : holdR;

  assign siOut        = siR;
  assign diOut        = diR;
  assign cxOut        = cxR;
  assign cxZero       = (cxR == '0);
  assign cxOne        = (cxR == REG_W'(1));
  assign flagPulse    = pulseR;
  assign zeroFlag     = zfR;
  assign carryFlag    = cfR;
  assign signFlag     = sfR;
  assign overflowFlag = ofR;

endmodule

// File: rtl/strseq_top.sv
module strseq_top
  import strseq_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = REG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opKind,
  input  logic              wordMode,
  input  logic [1:0]        repMode,
  input  logic              dirDown,
  input  logic              useOverride,
  input  logic [REG_W-1:0]  overrideSeg,
  input  logic [REG_W-1:0]  dsSeg,
  input  logic [REG_W-1:0]  esSeg,
  input  logic [REG_W-1:0]  siIn,
  input  logic [REG_W-1:0]  diIn,
  input  logic [REG_W-1:0]  cxIn,
  input  logic [REG_W-1:0]  axIn,
  output logic              memReq,
  output logic              memWe,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [REG_W-1:0]  memWdata,
  input  logic [REG_W-1:0]  memRdata,
  output logic              busy,
  output logic              done,
  output logic [REG_W-1:0]  siOut,
  output logic [REG_W-1:0]  diOut,
  output logic [REG_W-1:0]  cxOut,
  output logic              flagPulse,
  output logic              zeroFlag,
  output logic              carryFlag,
  output logic              signFlag,
  output logic              overflowFlag
);

  dpCtrl_t ctrl;
  logic    cxZero, cxOne;

  strseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .repMode(repMode),
    .cxZero(cxZero), .cxOne(cxOne), .zeroFlag(zeroFlag),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  strseq_dp #(.REG_W(REG_W), .SEG_SHIFT(SEG_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .wordMode(wordMode), .dirDown(dirDown), .useOverride(useOverride),
    .overrideSeg(overrideSeg), .dsSeg(dsSeg), .esSeg(esSeg),
    .siIn(siIn), .diIn(diIn), .cxIn(cxIn), .axIn(axIn), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memWord(memWord), .memAddr(memAddr),
    .memWdata(memWdata), .siOut(siOut), .diOut(diOut), .cxOut(cxOut),
    .cxZero(cxZero), .cxOne(cxOne), .flagPulse(flagPulse),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag), .signFlag(signFlag),
    .overflowFlag(overflowFlag)
  );

endmodule

// File: rtl/strseq_chk.sv
module strseq_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       opKind,
  input logic             busy,
  input logic             done,
  input logic             memReq,
  input logic             memWe,
  input logic             flagPulse,
  input logic [REG_W-1:0] cxOut
);

  logic [1:0] opSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              opSeen <= 2'd0;
    else if (start && !busy) opSeen <= opKind;
  end

  // R10: completion pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: completion happens inside the busy window
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R11: no memory traffic while idle
  a_r11_req_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R5: fill never reads memory
  a_r5_fill_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opSeen == 2'd1 && memReq) |-> memWe);

  // R6: flag pulse only for compare
  a_r6_pulse_on_compare: assert property (@(posedge clk) disable iff (!rstN)
    flagPulse |-> (opSeen == 2'd2));

  // R7: count holds or drops by one per cycle during an operation
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (cxOut == $past(cxOut) || cxOut == $past(cxOut) - REG_W'(1)));

endmodule

bind strseq_top strseq_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .busy(busy),
  .done(done), .memReq(memReq), .memWe(memWe), .flagPulse(flagPulse),
  .cxOut(cxOut)
);

// File: tb/strseq_top_tb.sv
module strseq_top_tb;
  localparam int REG_W = 16;
  localparam int SEG_SHIFT = 4;
  localparam int ADDR_W = REG_W + SEG_SHIFT;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, start, wordMode, dirDown, useOverride;
  logic [1:0] opKind, repMode;
  logic [15:0] overrideSeg, dsSeg, esSeg, siIn, diIn, cxIn, axIn;
  logic memReq, memWe, memWord;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic busy, done, flagPulse, zeroFlag, carryFlag, signFlag, overflowFlag;
  logic [15:0] siOut, diOut, cxOut;

  strseq_top #(.REG_W(REG_W), .SEG_SHIFT(SEG_SHIFT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .wordMode(wordMode),
    .repMode(repMode), .dirDown(dirDown), .useOverride(useOverride),
    .overrideSeg(overrideSeg), .dsSeg(dsSeg), .esSeg(esSeg), .siIn(siIn),
    .diIn(diIn), .cxIn(cxIn), .axIn(axIn), .memReq(memReq), .memWe(memWe),
    .memWord(memWord), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .siOut(siOut),
    .diOut(diOut), .cxOut(cxOut), .flagPulse(flagPulse), .zeroFlag(zeroFlag),
    .carryFlag(carryFlag), .signFlag(signFlag), .overflowFlag(overflowFlag)
  );

  // Little-endian byte memory, 4 KiB window on the low address bits
  logic [7:0] mem [0:4095];
  wire [11:0] aLo = memAddr[11:0];
  wire [11:0] aHi = aLo + 12'd1;
  int accCnt = 0, rdCnt = 0, pulseCnt = 0;

  always @(posedge clk) begin
    if (memReq) begin
      accCnt <= accCnt + 1;
      if (memWe) begin
        mem[aLo] <= memWdata[7:0];
        if (memWord) mem[aHi] <= memWdata[15:8];
      end else begin
        rdCnt    <= rdCnt + 1;
        memRdata <= {memWord ? mem[aHi] : 8'h00, mem[aLo]};
      end
    end
    if (flagPulse) pulseCnt <= pulseCnt + 1;
  end

  int nChecks = 0, nFails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic runOp(input logic [1:0] op, input logic wd, input logic [1:0] rep,
                       input logic dn, input logic ovr, input logic [15:0] oseg,
                       input logic [15:0] ds, input logic [15:0] es,
                       input logic [15:0] si, input logic [15:0] di,
                       input logic [15:0] cx, input logic [15:0] ax);
    int waitCnt;
    @(negedge clk);
    opKind = op; wordMode = wd; repMode = rep; dirDown = dn; useOverride = ovr;
    overrideSeg = oseg; dsSeg = ds; esSeg = es; siIn = si; diIn = di; cxIn = cx; axIn = ax;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) chk("R10 timeout waiting for done", 0, 1);
  endtask

  task automatic testReset();
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R11 reset memReq", memReq, 0);
    chk("R7 reset cx", cxOut, 0);
  endtask

  task automatic testCopyByteOnce();
    clearMem();
    mem[12'h105] = 8'hA5;
    runOp(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0005, 16'h0007, 16'h0009, 16'h0);
    chk("R4 copied byte", mem[12'h207], 8'hA5);
    chk("R3 si up by 1", siOut, 16'h0006);
    chk("R3 di up by 1", diOut, 16'h0008);
    chk("R7 once keeps count", cxOut, 16'h0009);
  endtask

  task automatic testCopyWordDownOverride();
    clearMem();
    for (int i = 0; i < 6; i++) begin
      mem[12'h300 + i] = 8'h11 + 8'(i);
      mem[12'h100 + i] = 8'hEE;
    end
    runOp(2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 16'h0030, 16'h0010, 16'h0020, 16'h0004, 16'h0014, 16'h0003, 16'h0);
    chk("R2 override low word lo", mem[12'h210], 8'h11);
    chk("R2 override top word hi", mem[12'h215], 8'h16);
    chk("R4 middle word", {mem[12'h213], mem[12'h212]}, 16'h1413);
    chk("R3 si down wraps", siOut, 16'hFFFE);
    chk("R3 di down by 6", diOut, 16'h000E);
    chk("R7 count exhausted", cxOut, 16'h0000);
  endtask

  task automatic testFillWord();
    int rd0, acc0;
    clearMem();
    rd0 = rdCnt; acc0 = accCnt;
    runOp(2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0040, 16'h1234, 16'h0001, 16'h0004, 16'hBEEF);
    chk("R4 little-endian low byte", mem[12'h401], 8'hEF);
    chk("R5 fill last word", {mem[12'h408], mem[12'h407]}, 16'hBEEF);
    chk("R5 si untouched", siOut, 16'h1234);
    chk("R5 di up by 8", diOut, 16'h0009);
    chk("R5 no reads", rdCnt - rd0, 0);
    chk("R8 fill ignores zf, all writes", accCnt - acc0, 4);
  endtask

  task automatic testCmpWhileEqual();
    int p0;
    logic [7:0] srcB [5] = '{8'hAB, 8'hCD, 8'hEF, 8'h01, 8'h02};
    logic [7:0] dstB [5] = '{8'hAB, 8'hCD, 8'hEE, 8'h01, 8'h02};
    clearMem();
    for (int i = 0; i < 5; i++) begin
      mem[12'h140 + i] = srcB[i];
      mem[12'h260 + i] = dstB[i];
    end
    p0 = pulseCnt;
    runOp(2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0040, 16'h0060, 16'h0005, 16'h0);
    chk("R8 equal-repeat stops, count", cxOut, 16'h0002);
    chk("R8 equal-repeat stops, si", siOut, 16'h0043);
    chk("R6 di steps on compare", diOut, 16'h0063);
    chk("R6 zf clear on diff", zeroFlag, 0);
    chk("R6 one pulse per element", pulseCnt - p0, 3);
  endtask

  task automatic testCmpWhileUnequal();
    clearMem();
    mem[12'h150] = 8'h01; mem[12'h152] = 8'h02; mem[12'h154] = 8'h03;
    mem[12'h270] = 8'h09; mem[12'h272] = 8'h02; mem[12'h274] = 8'h07;
    runOp(2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0050, 16'h0070, 16'h0004, 16'h0);
    chk("R8 unequal-repeat stops, count", cxOut, 16'h0002);
    chk("R8 unequal-repeat stops, si", siOut, 16'h0054);
    chk("R6 zf set on match", zeroFlag, 1);
    chk("R6 cf clear on match", carryFlag, 0);
  endtask

  task automatic testCmpFlags();
    clearMem();
    mem[12'h180] = 8'h34; mem[12'h181] = 8'h12;
    mem[12'h280] = 8'h35; mem[12'h281] = 8'h12;
    runOp(2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0080, 16'h0080, 16'h0007, 16'h0);
    chk("R6 borrow flags", {zeroFlag, carryFlag, signFlag, overflowFlag}, 4'b0110);
    chk("R7 once compare keeps count", cxOut, 16'h0007);
    chk("R6 si up by 2", siOut, 16'h0082);
    mem[12'h184] = 8'h00; mem[12'h185] = 8'h80;
    mem[12'h284] = 8'h01; mem[12'h285] = 8'h00;
    runOp(2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0084, 16'h0084, 16'h0001, 16'h0);
    chk("R6 overflow flags", {zeroFlag, carryFlag, signFlag, overflowFlag}, 4'b0001);
  endtask

  task automatic testZeroCount();
    int acc0;
    clearMem();
    acc0 = accCnt;
    runOp(2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0011, 16'h0022, 16'h0000, 16'h0);
    chk("R9 no memory access", accCnt - acc0, 0);
    chk("R9 count stays zero", cxOut, 16'h0000);
    chk("R9 si unchanged", siOut, 16'h0011);
    chk("R9 di unchanged", diOut, 16'h0022);
  endtask

  task automatic testCopyIgnoresZf();
    clearMem();
    mem[12'h120] = 8'h01; mem[12'h121] = 8'h02; mem[12'h122] = 8'h03;
    mem[12'h220] = 8'h55; mem[12'h221] = 8'h66; mem[12'h222] = 8'h77;
    runOp(2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0, 16'h0010, 16'h0020, 16'h0020, 16'h0020, 16'h0003, 16'h0);
    chk("R8 copy runs to end, count", cxOut, 16'h0000);
    chk("R8 copy last byte", mem[12'h222], 8'h03);
  endtask

  task automatic testWrap();
    clearMem();
    mem[12'h010] = 8'h5C;
    runOp(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'hFFFF, 16'h0000, 16'h0020, 16'hFFFF, 16'h0001, 16'h0);
    chk("R1 segment wrap address", mem[12'hFFF], 8'h5C);
    chk("R3 di wraps to zero", diOut, 16'h0000);
    chk("R3 si up", siOut, 16'h0021);
  endtask

  task automatic testStartWhileBusy();
    int waitCnt;
    clearMem();
    @(negedge clk);
    opKind = 2'd1; wordMode = 1'b0; repMode = 2'd2; dirDown = 1'b0; useOverride = 1'b0;
    dsSeg = 16'h0010; esSeg = 16'h0050; siIn = 16'h0; diIn = 16'h0000; cxIn = 16'h0003; axIn = 16'h0033;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, 1);
    chk("R10 no early done", done, 0);
    @(negedge clk);
    opKind = 2'd0; diIn = 16'h0080; cxIn = 16'h0010; axIn = 16'h0099;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk("R11 second start ignored, di", diOut, 16'h0003);
    chk("R11 second start ignored, count", cxOut, 16'h0000);
    chk("R5 byte fill uses low byte", mem[12'h502], 8'h33);
    chk("R11 no stray write", mem[12'h580], 8'h00);
    @(negedge clk);
    chk("R10 done lasts one cycle", done, 0);
    chk("R10 idle after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; opKind = 2'd0; wordMode = 1'b0; repMode = 2'd0;
    dirDown = 1'b0; useOverride = 1'b0; overrideSeg = '0; dsSeg = '0; esSeg = '0;
    siIn = '0; diIn = '0; cxIn = '0; axIn = '0; memRdata = '0;
    clearMem();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCopyByteOnce();
    testCopyWordDownOverride();
    testFillWord();
    testCmpWhileEqual();
    testCmpWhileUnequal();
    testCmpFlags();
    testZeroCount();
    testCopyIgnoresZf();
    testWrap();
    testStartWhileBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule